// File: doc/BRIEF.md
# Two-Core Hardware Semaphore Unit

This block gives two processors a shared set of sixteen hardware mutex gates. Each gate holds a two-bit ownership code: zero when free, otherwise the code of the core holding it. A core claims a gate by writing its own code to the gate's byte and releases it by writing zero. Any other write is turned away by rules the hardware enforces, so no read-modify-write race between the cores can corrupt ownership.

A core whose claim is refused is remembered as the gate's waiter. When the owner later releases the gate, a notification bit is raised for the waiter. Each core has its own notification vector and its own enable mask. A per-core interrupt line is raised whenever an enabled notification is pending, so the losing core can sleep until it is worth retrying. Both the notification vectors and the enable masks are seen through a 32-bit window whose sixteen bits sit in the upper halfword with the gate nibbles in reversed order.

Accesses arrive on a simple single-cycle synchronous bus. The bus has a byte/word size flag and a master input that names the issuing core. Read data is returned combinationally in the same cycle as the request.

Top module: `sema_top`

## Requirements
- R1: A byte read at offset g (0..15) returns the ownership code of gate g in bits 1:0 and zero elsewhere: 0 means free, 1 means core 0, 2 means core 1. A 32-bit read at a 4-aligned offset a below 16 returns gate a+k in byte lane k.
- R2: A gate write whose byte value is 3 or more leaves ownership, waiter and notification state untouched.
- R3: A core's code is its master input plus one. Writing that code to a gate succeeds when the gate is free or already held by the same core, and the gate then reads that code.
- R4: A write of code 1 or 2 that does not succeed leaves the gate unchanged and records the writing core as the gate's waiter.
- R5: Writing 0 to a gate frees it only when the writer owns it. A zero write by any other core has no effect.
- R6: A successful release of a gate with a recorded waiter sets that gate's notification bit for the waiter's core. The waiter record is kept.
- R7: A successful claim of a gate with a recorded waiter clears that gate's notification bits for both cores. The waiter record is cleared only when the claiming core is the waiter.
- R8: A 32-bit write to offset 0x40 loads core 0's enable mask and one to 0x48 loads core 1's, both taken from bits 31:16. A 32-bit read of either offset returns that core's own mask in the same position.
- R9: Each core's interrupt output is high exactly when some gate has both its notification bit and its enable bit set for that core.
- R10: In the enable and status words, register bit 16+i stands for gate i XOR 12. The nibbles are reversed and bit order inside each nibble is kept.
- R11: 32-bit reads of 0x80 and 0x88 return the notification vectors of core 0 and core 1, and writes there have no effect. Reads of any other offset outside the gates return 0, byte writes outside the gates are ignored, and word writes to other offsets are ignored.
- R12: A 32-bit write to a 4-aligned offset below 16 applies each byte lane k as an independent gate write to gate a+k, all in the same cycle.
- R13: Reset frees every gate and clears waiters, both enable masks and both notification vectors, so both interrupt outputs are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| busEn | input | 1 | Access valid this cycle |
| busWe | input | 1 | 1 for a write, 0 for a read |
| busWide | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| busMaster | input | 1 | Issuing core: 0 or 1 |
| busAddr | input | ADDR_W | Byte offset of the access |
| busWdata | input | 32 | Write data; a byte access uses bits 7:0 |
| busRdata | output | 32 | Read data, valid in the cycle of the read |
| irqCore0 | output | 1 | Pending enabled notification for core 0 |
| irqCore1 | output | 1 | Pending enabled notification for core 1 |

## Verification
On every cycle the checker enforces the ownership rules that depend only on the current access and the state: bad byte values, foreign releases, claims of free gates, the read-only status window, the range of gate read data, the reset clear, and that an interrupt can rise only after a write. The waiter bookkeeping cannot be seen from a single cycle. This covers notification set on release, the cross-core clearing on a later claim, and whether the waiter survives it. These are shown by the bench's scenarios and by its behavioural model, which is compared against read data and both interrupt lines throughout long mixed traffic.

// File: rtl/sema_pkg.sv
package sema_pkg;
  localparam int GATES  = 16;
  localparam int CORES  = 2;
  localparam int CODE_W = 2;
  localparam int LANES  = 4;
  localparam int NIBS   = GATES / 4;

  localparam int OFF_EN0 = 'h40;
  localparam int OFF_EN1 = 'h48;
  localparam int OFF_ST0 = 'h80;
  localparam int OFF_ST1 = 'h88;

  typedef logic [GATES-1:0] gateVec_t;
  typedef logic [GATES-1:0][CODE_W-1:0] ownerArr_t;
  typedef logic [CORES-1:0][GATES-1:0] maskArr_t;

  typedef struct packed {
    gateVec_t              unlockReq;
    gateVec_t              lockTry;
    gateVec_t              codeMatch;
    logic [CODE_W-1:0]     code;
    logic [CORES-1:0]      enWr;
    gateVec_t              enVal;
  } strobe_t;

  // Register view <-> gate view; the mapping is its own inverse.
  function automatic gateVec_t swapNibbles(gateVec_t v);
    gateVec_t r;
    for (int i = 0; i < GATES; i++) begin
      r[i] = v[(NIBS - 1 - i / 4) * 4 + (i % 4)];
    end
    return r;
  endfunction
endpackage

// File: rtl/sema_gate.sv
module sema_gate
  import sema_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              unlockReq,
  input  logic              lockTry,
  input  logic              codeMatch,
  input  logic [CODE_W-1:0] code,
  output logic [CODE_W-1:0] owner,
  output logic [CORES-1:0]  notif
);
  logic [CODE_W-1:0] waiter;
  logic              ownerFreeOrSelf;

  assign ownerFreeOrSelf = (owner == '0) || (owner == code);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      owner  <= '0;
      waiter <= '0;
      notif  <= '0;
    end else if (unlockReq) begin
      if (owner == code) begin
        owner <= '0;
        for (int c = 0; c < CORES; c++) begin
          if (waiter == CODE_W'(c + 1)) notif[c] <= 1'b1;
        end
      end
    end else if (lockTry) begin
      if (codeMatch && ownerFreeOrSelf) begin
        owner <= code;
        if (waiter != '0) begin
          notif <= '0;
          if (waiter == code) waiter <= '0;
        end
      end else begin
        waiter <= code;
      end
    end
  end
endmodule

// File: rtl/sema_dp.sv
module sema_dp
  import sema_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          stb,
  output ownerArr_t        ownerArr,
  output maskArr_t         enMask,
  output maskArr_t         notifMask,
  output logic [CORES-1:0] irq
);
  logic [GATES-1:0][CORES-1:0] notifByGate;

  for (genvar g = 0; g < GATES; g++) begin : gen_gate
    sema_gate u_gate (
      .clk       (clk),
      .rstN      (rstN),
      .unlockReq (stb.unlockReq[g]),
      .lockTry   (stb.lockTry[g]),
      .codeMatch (stb.codeMatch[g]),
      .code      (stb.code),
      .owner     (ownerArr[g]),
      .notif     (notifByGate[g])
    );
  end

  always_comb begin
    for (int c = 0; c < CORES; c++) begin
      for (int g = 0; g < GATES; g++) begin
        notifMask[c][g] = notifByGate[g][c];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enMask <= '0;
    end else begin
      for (int c = 0; c < CORES; c++) begin
        if (stb.enWr[c]) enMask[c] <= stb.enVal;
      end
    end
  end

  for (genvar c = 0; c < CORES; c++) begin : gen_irq
    assign irq[c] = |(notifMask[c] & enMask[c]);
  end
endmodule

// File: rtl/sema_ctrl.sv
module sema_ctrl
  import sema_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              busEn,
  input  logic              busWe,
  input  logic              busWide,
  input  logic              busMaster,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  input  ownerArr_t         ownerArr,
  input  maskArr_t          enMask,
  input  maskArr_t          notifMask,
  output strobe_t           stb,
  output logic [31:0]       busRdata
);
  localparam int GIDX_W = $clog2(GATES);

  logic [ADDR_W-1:0] wordAddr;
  logic              inGates;
  logic              wordInGates;
  logic              wrCycle;
  logic              rdCycle;

  assign wordAddr    = {busAddr[ADDR_W-1:2], 2'b00};
  assign inGates     = busAddr < ADDR_W'(GATES);
  assign wordInGates = wordAddr < ADDR_W'(GATES);
  assign wrCycle     = busEn && busWe;
  assign rdCycle     = busEn && !busWe;

  // Write decode: per-gate strobes plus enable loads.
  always_comb begin
    logic       hitG;
    logic [7:0] valG;
    stb      = '0;
    stb.code = busMaster ? CODE_W'(2) : CODE_W'(1);
    for (int g = 0; g < GATES; g++) begin
      hitG = 1'b0;
      valG = '0;
      if (wrCycle) begin
        if (!busWide) begin
          hitG = inGates && (busAddr[GIDX_W-1:0] == GIDX_W'(g));
          valG = busWdata[7:0];
        end else begin
          hitG = wordInGates && (int'(wordAddr) == (g & ~3));
          valG = busWdata[8*(g%LANES) +: 8];
        end
      end
      if (hitG) begin
        if (valG == 8'd0) begin
          stb.unlockReq[g] = 1'b1;
        end else if (valG <= 8'd2) begin
          stb.lockTry[g]   = 1'b1;
          stb.codeMatch[g] = (valG[CODE_W-1:0] == stb.code);
        end
      end
    end
    if (wrCycle && busWide) begin
      stb.enWr[0] = (int'(wordAddr) == OFF_EN0);
      stb.enWr[1] = (int'(wordAddr) == OFF_EN1);
    end
    stb.enVal = swapNibbles(busWdata[31:16]);
  end

  // Read mux.
  always_comb begin
    busRdata = '0;
    if (rdCycle) begin
      if (!busWide) begin
        if (inGates) busRdata[CODE_W-1:0] = ownerArr[busAddr[GIDX_W-1:0]];
      end else if (wordInGates) begin
        for (int k = 0; k < LANES; k++) begin
          busRdata[8*k +: CODE_W] = ownerArr[{wordAddr[GIDX_W-1:2], 2'(k)}];
        end
      end else begin
        case (int'(wordAddr))
          OFF_EN0: busRdata[31:16] = swapNibbles(enMask[0]);
          OFF_EN1: busRdata[31:16] = swapNibbles(enMask[1]);
          OFF_ST0: busRdata[31:16] = swapNibbles(notifMask[0]);
          OFF_ST1: busRdata[31:16] = swapNibbles(notifMask[1]);
          default: busRdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/sema_top.sv
module sema_top
  import sema_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busEn,
  input  logic              busWe,
  input  logic              busWide,
  input  logic              busMaster,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  output logic              irqCore0,
  output logic              irqCore1
);
  strobe_t          stb;
  ownerArr_t        ownerArr;
  maskArr_t         enMask;
  maskArr_t         notifMask;
  logic [CORES-1:0] irq;

  sema_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .busEn     (busEn),
    .busWe     (busWe),
    .busWide   (busWide),
    .busMaster (busMaster),
    .busAddr   (busAddr),
    .busWdata  (busWdata),
    .ownerArr  (ownerArr),
    .enMask    (enMask),
    .notifMask (notifMask),
    .stb       (stb),
    .busRdata  (busRdata)
  );

  sema_dp u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .ownerArr  (ownerArr),
    .enMask    (enMask),
    .notifMask (notifMask),
    .irq       (irq)
  );

  assign irqCore0 = irq[0];
  assign irqCore1 = irq[1];
endmodule

// File: rtl/sema_chk.sv
module sema_chk
  import sema_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              busEn,
  input logic              busWe,
  input logic              busWide,
  input logic              busMaster,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busWdata,
  input logic [31:0]       busRdata,
  input logic              irqCore0,
  input logic              irqCore1,
  input ownerArr_t         ownerArr,
  input maskArr_t          enMask,
  input maskArr_t          notifMask
);
  localparam int GIDX_W = $clog2(GATES);

  logic [GIDX_W-1:0] idx;
  logic [CODE_W-1:0] code;
  logic              byteGateWr;
  logic              byteGateRd;
  logic              statusWr;
  logic [ADDR_W-1:0] wordAddr;

  assign idx        = busAddr[GIDX_W-1:0];
  assign code       = busMaster ? CODE_W'(2) : CODE_W'(1);
  assign wordAddr   = {busAddr[ADDR_W-1:2], 2'b00};
  assign byteGateWr = busEn && busWe && !busWide && (busAddr < ADDR_W'(GATES));
  assign byteGateRd = busEn && !busWe && !busWide && (busAddr < ADDR_W'(GATES));
  assign statusWr   = busEn && busWe && busWide &&
                      ((int'(wordAddr) == OFF_ST0) || (int'(wordAddr) == OFF_ST1));

  // R2
  a_r2_bad_value_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (byteGateWr && busWdata[7:0] > 8'd2) |=> ($stable(ownerArr) && $stable(notifMask)));

  // R5
  a_r5_foreign_release_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (byteGateWr && busWdata[7:0] == 8'd0 && ownerArr[idx] != code) |=> $stable(ownerArr));

  // R3
  a_r3_claim_free_gate: assert property (@(posedge clk) disable iff (!rstN)
    (byteGateWr && busWdata[7:0] == 8'(code) && ownerArr[idx] == '0)
      |=> ownerArr[$past(idx)] == $past(code));

  // R1
  a_r1_gate_read_range: assert property (@(posedge clk) disable iff (!rstN)
    byteGateRd |-> (busRdata[31:CODE_W] == '0 && busRdata[CODE_W-1:0] != 2'd3));

  // R11
  a_r11_status_readonly: assert property (@(posedge clk) disable iff (!rstN)
    statusWr |=> ($stable(notifMask) && $stable(enMask)));

  // R9
  a_r9_irq0_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqCore0) |-> $past(busEn && busWe));
  a_r9_irq1_after_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqCore1) |-> $past(busEn && busWe));

  // R13
  a_r13_reset_clears: assert property (@(posedge clk)
    !rstN |=> (ownerArr == '0 && enMask == '0 && notifMask == '0 && !irqCore0 && !irqCore1));
endmodule

bind sema_top sema_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_sema_top.sv
module sim_sema_top;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 9;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busEn = 1'b0;
  logic              busWe = 1'b0;
  logic              busWide = 1'b0;
  logic              busMaster = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWdata = '0;
  logic [31:0]       busRdata;
  logic              irqCore0;
  logic              irqCore1;

  int nChecks = 0;
  int nErr    = 0;
  bit compareOn = 1'b0;
  bit finished  = 1'b0;

  // Behavioural reference state.
  int       mOwn[16];
  int       mWait[16];
  bit [15:0] mN0, mN1, mEn0, mEn1;

  always #(CLK_PERIOD/2) clk = ~clk;

  sema_top #(.ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .busEn(busEn), .busWe(busWe), .busWide(busWide),
    .busMaster(busMaster), .busAddr(busAddr), .busWdata(busWdata),
    .busRdata(busRdata), .irqCore0(irqCore0), .irqCore1(irqCore1)
  );

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic void modelReset();
    for (int g = 0; g < 16; g++) begin mOwn[g] = 0; mWait[g] = 0; end
    mN0 = '0; mN1 = '0; mEn0 = '0; mEn1 = '0;
  endfunction

  // R10: register bit i <-> gate i^12
  function automatic bit [15:0] regToGate(bit [15:0] r);
    bit [15:0] v;
    for (int i = 0; i < 16; i++) v[i ^ 12] = r[i];
    return v;
  endfunction
  function automatic bit [15:0] gateToReg(bit [15:0] v);
    bit [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[i ^ 12];
    return r;
  endfunction

  function automatic void modelGate(int g, int v, int master);
    int id = master + 1;
    if (v > 2) return;
    if (v == 0) begin
      if (mOwn[g] == id) begin
        mOwn[g] = 0;
        if (mWait[g] == 1) mN0[g] = 1'b1;
        if (mWait[g] == 2) mN1[g] = 1'b1;
      end
    end else if (v == id && (mOwn[g] == 0 || mOwn[g] == id)) begin
      mOwn[g] = id;
      if (mWait[g] != 0) begin
        mN0[g] = 1'b0; mN1[g] = 1'b0;
        if (mWait[g] == id) mWait[g] = 0;
      end
    end else begin
      mWait[g] = id;
    end
  endfunction

  function automatic void modelWrite(bit wide, bit master, int addr, logic [31:0] d);
    int wa = addr & ~3;
    if (!wide) begin
      if (addr < 16) modelGate(addr, int'(d[7:0]), master);
    end else if (wa < 16) begin
      for (int k = 0; k < 4; k++) modelGate(wa + k, int'(d[8*k +: 8]), master);
    end else if (wa == 'h40) mEn0 = regToGate(d[31:16]);
    else if (wa == 'h48) mEn1 = regToGate(d[31:16]);
  endfunction

  function automatic logic [31:0] modelRead(bit wide, int addr);
    int wa = addr & ~3;
    logic [31:0] r = '0;
    if (!wide) begin
      if (addr < 16) r = 32'(mOwn[addr]);
    end else if (wa < 16) begin
      for (int k = 0; k < 4; k++) r[8*k +: 8] = 8'(mOwn[wa + k]);
    end else if (wa == 'h40) r = {gateToReg(mEn0), 16'h0};
    else if (wa == 'h48) r = {gateToReg(mEn1), 16'h0};
    else if (wa == 'h80) r = {gateToReg(mN0), 16'h0};
    else if (wa == 'h88) r = {gateToReg(mN1), 16'h0};
    return r;
  endfunction

  // One bus access; reads compared against the model in the same cycle.
  task automatic acc(bit we, bit wide, bit master, int addr, logic [31:0] d, string tag);
    logic [31:0] e;
    @(negedge clk);
    busEn = 1'b1; busWe = we; busWide = wide; busMaster = master;
    busAddr = ADDR_W'(addr); busWdata = d;
    #1;
    if (!we) begin
      e = modelRead(wide, addr);
      chk(busRdata === e, tag, busRdata, e);
    end
    @(posedge clk);
    if (we) modelWrite(wide, master, addr, d);
  endtask

  task automatic idle();
    @(negedge clk);
    busEn = 1'b0; busWe = 1'b0;
  endtask

  task automatic wr(bit wide, bit master, int addr, logic [31:0] d, string tag);
    acc(1'b1, wide, master, addr, d, tag);
  endtask

  // Read, compared with the model and with a literal expectation.
  task automatic rdLit(bit wide, int addr, logic [31:0] exp, string tag);
    acc(1'b0, wide, 1'b0, addr, 32'h0, tag);
    chk(busRdata === exp, tag, busRdata, exp);
  endtask

  task automatic irqLit(bit e0, bit e1, string tag);
    idle();
    #1;
    chk({irqCore1, irqCore0} === {e1, e0}, tag, {30'h0, irqCore1, irqCore0}, {30'h0, e1, e0});
  endtask

  task automatic doReset();
    @(negedge clk);
    compareOn = 1'b0;
    busEn = 1'b0;
    rstN = 1'b0;
    modelReset();
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    compareOn = 1'b1;
  endtask

  // R9: interrupt lines compared with the model on every clock.
  always @(negedge clk) begin
    if (compareOn && rstN) begin
      chk({irqCore1, irqCore0} === {|(mN1 & mEn1), |(mN0 & mEn0)}, "R9 per-cycle irq",
          {30'h0, irqCore1, irqCore0}, {30'h0, |(mN1 & mEn1), |(mN0 & mEn0)});
    end
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      nChecks++; nErr++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", nErr, nChecks);
      $finish;
    end
  end

  initial begin
    modelReset();
    doReset();

    // R13 reset state
    rdLit(1'b1, 'h00, 32'h0, "R13 gates free");
    rdLit(1'b1, 'h0C, 32'h0, "R13 gates free hi");
    rdLit(1'b1, 'h40, 32'h0, "R13 enable0 clear");
    rdLit(1'b1, 'h88, 32'h0, "R13 status1 clear");
    irqLit(1'b0, 1'b0, "R13 irq low");

    // R3 claim and re-claim
    wr(1'b0, 1'b0, 3, 32'h1, "R3 claim");
    rdLit(1'b0, 3, 32'h1, "R3 owner core0");
    rdLit(1'b1, 'h00, 32'h0100_0000, "R1 word lane3");
    wr(1'b0, 1'b0, 3, 32'h1, "R3 reclaim");
    rdLit(1'b0, 3, 32'h1, "R3 reclaim keeps");

    // R4 refused claim
    wr(1'b0, 1'b1, 3, 32'h2, "R4 refused");
    rdLit(1'b0, 3, 32'h1, "R4 unchanged");

    // R8 / R10 enable core1 for gate 3 -> register bit 31
    wr(1'b1, 1'b0, 'h48, 32'h8000_0000, "R8 enable1");
    rdLit(1'b1, 'h48, 32'h8000_0000, "R8 R10 enable1 readback");
    rdLit(1'b1, 'h40, 32'h0, "R8 enable0 own mask");

    // R5 foreign release
    wr(1'b0, 1'b1, 3, 32'h0, "R5 foreign release");
    rdLit(1'b0, 3, 32'h1, "R5 still owned");
    // R2 bad values
    wr(1'b0, 1'b0, 3, 32'h5, "R2 value 5");
    wr(1'b0, 1'b0, 3, 32'hFF, "R2 value ff");
    rdLit(1'b0, 3, 32'h1, "R2 still owned");
    irqLit(1'b0, 1'b0, "R2 no irq");

    // R6 release with waiter core1
    wr(1'b0, 1'b0, 3, 32'h0, "R6 release");
    rdLit(1'b0, 3, 32'h0, "R5 owner release frees");
    irqLit(1'b0, 1'b1, "R9 irq1 high");
    rdLit(1'b1, 'h88, 32'h8000_0000, "R6 R10 status1 bit");
    rdLit(1'b1, 'h80, 32'h0, "R6 status0 clear");

    // R11 status read-only
    wr(1'b1, 1'b0, 'h88, 32'h0, "R11 status write");
    rdLit(1'b1, 'h88, 32'h8000_0000, "R11 status unchanged");

    // R7 claim by waiter clears notification and waiter
    wr(1'b0, 1'b1, 3, 32'h2, "R7 waiter claims");
    rdLit(1'b0, 3, 32'h2, "R3 owner core1");
    rdLit(1'b1, 'h88, 32'h0, "R7 notif cleared");
    irqLit(1'b0, 1'b0, "R7 irq1 low");
    wr(1'b0, 1'b1, 3, 32'h0, "R7 release no waiter");
    rdLit(1'b1, 'h88, 32'h0, "R7 waiter was cleared");

    // R7 claim by non-waiter keeps waiter; gate 5 -> register bit 25
    wr(1'b0, 1'b0, 5, 32'h1, "R7 g5 claim");
    wr(1'b0, 1'b1, 5, 32'h2, "R4 g5 refused");
    wr(1'b0, 1'b0, 5, 32'h0, "R6 g5 release");
    rdLit(1'b1, 'h88, 32'h0200_0000, "R6 g5 notif");
    wr(1'b0, 1'b0, 5, 32'h1, "R7 g5 reclaim by owner");
    rdLit(1'b1, 'h88, 32'h0, "R7 g5 notif cleared");
    wr(1'b0, 1'b0, 5, 32'h0, "R7 g5 release again");
    rdLit(1'b1, 'h88, 32'h0200_0000, "R7 waiter kept");

    // R12 word write: lanes 1,3,1,2 from core0
    wr(1'b1, 1'b0, 'h04, 32'h0201_0301, "R12 word write");
    rdLit(1'b1, 'h04, 32'h0001_0001, "R12 lanes independent");

    // R11 unmapped and byte accesses outside gates
    rdLit(1'b1, 'h100, 32'h0, "R11 unmapped word");
    rdLit(1'b0, 'h40, 32'h0, "R11 byte read outside");
    wr(1'b0, 1'b0, 'h40, 32'hFF, "R11 byte write outside");
    rdLit(1'b1, 'h40, 32'h0, "R11 enable0 untouched");

    // R10 enable0 bit 16 -> gate 12
    wr(1'b1, 1'b0, 'h40, 32'h0001_0000, "R10 enable0");
    rdLit(1'b1, 'h40, 32'h0001_0000, "R10 enable0 readback");

    // Mixed traffic against the model
    for (int n = 0; n < 4000; n++) begin
      int sel = $urandom_range(0, 19);
      bit m = 1'($urandom_range(0, 1));
      int a;
      logic [31:0] d;
      if (sel < 10) begin
        a = $urandom_range(0, 15);
        d = ($urandom_range(0, 9) == 0) ? 32'($urandom_range(3, 255)) : 32'($urandom_range(0, 2));
        wr(1'b0, m, a, d, "R3 R4 R5 random gate");
      end else if (sel < 12) begin
        a = $urandom_range(0, 3) * 4;
        d = $urandom & 32'h0303_0303;
        wr(1'b1, m, a, d, "R12 random word");
      end else if (sel < 13) begin
        a = ($urandom_range(0, 1) == 0) ? 'h40 : 'h48;
        wr(1'b1, m, a, $urandom, "R8 random enable");
      end else if (sel < 16) begin
        acc(1'b0, 1'b0, m, $urandom_range(0, 15), 32'h0, "R1 random byte read");
      end else begin
        case ($urandom_range(0, 5))
          0: a = 'h40; 1: a = 'h48; 2: a = 'h80; 3: a = 'h88; 4: a = 'h100;
          default: a = $urandom_range(0, 3) * 4;
        endcase
        acc(1'b0, 1'b1, m, a, 32'h0, "R11 random word read");
      end
    end

    // R13 reset mid-run
    doReset();
    rdLit(1'b1, 'h00, 32'h0, "R13 gates free after reset");
    rdLit(1'b1, 'h04, 32'h0, "R13 gates free after reset 2");
    rdLit(1'b1, 'h48, 32'h0, "R13 enable1 clear");
    rdLit(1'b1, 'h80, 32'h0, "R13 status0 clear");
    irqLit(1'b0, 1'b0, "R13 irq low after reset");

    idle();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule